// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Transmitter

This block turns 16-bit audio samples into a self-clocking serial line of the consumer digital-audio kind. It takes a sample from one of two producers: the decoded PCM path or the burst formatter, as picked by a select input. Each sample becomes one 32-slot subframe, made of a 4-slot sync preamble, eight zero auxiliary slots, the sample itself, and four flag slots. Every slot goes out as two half-bit line states.

Line timing comes from a clock-enable strobe at twice the slot rate. Each strobe moves the line one half-bit. A subframe lasts exactly 64 strobes. Source select, sample word, valid and channel flag are sampled once, at the strobe that begins a subframe. The block runs without stopping: if the selected source has no valid sample at that strobe, a zero sample goes out with its validity flag raised.

A constant channel-status word, one bit per frame of a 192-frame block, is a parameter. The frame position is tracked internally from the channel-A subframes.

Top module: `spdif_biphase_tx`

## Requirements
- R1: While reset is held and after its release until the first strobe, the line output is low.
- R2: With src_sel=0 the subframe carries the PCM word and PCM valid; with src_sel=1 it carries the formatter word and formatter valid.
- R3: Subframe slots 4 to 11 are zero, and slots 12 to 27 carry the 16-bit sample least significant bit first (slot 12 = bit 0).
- R4: Slot 28 (validity) is 1 exactly when the selected valid was low, and in that case slots 12 to 27 are all zero. Slot 29 (user) is always 0.
- R5: Slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R6: For slots 4 to 31, the line toggles at the first half of every slot, and toggles again at the second half only when the slot value is 1.
- R7: The line is low at every subframe boundary. The eight preamble half-states are 11100010 for a channel-A subframe (chan_b=0) and 11100100 for channel B (chan_b=1), sent first state first.
- R8: The first channel-A subframe after reset, and then every 192nd one, uses the block-start preamble 11101000 in place of the channel-A pattern.
- R9: Slot 30 carries bit k of the channel-status parameter, where k is the frame index (0 to 191) of the current channel-A subframe. A channel-B subframe reuses the index of the most recent channel-A subframe (0 before any).
- R10: The line output changes only on clock edges where half_en is high.
- R11: A subframe spans exactly 64 strobes. The inputs are taken only at the strobe that begins it, so input changes during a subframe do not affect that subframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Half-bit strobe, twice the slot rate |
| pcm_word | input | 16 | Sample from the decoded PCM path |
| pcm_vld | input | 1 | PCM sample valid |
| fmt_word | input | 16 | Sample from the burst formatter |
| fmt_vld | input | 1 | Formatter sample valid |
| src_sel | input | 1 | 0 selects PCM, 1 selects formatter |
| chan_b | input | 1 | 0 for channel A subframe, 1 for channel B |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
The properties assume that half_en is a clean single-cycle-per-step strobe sampled on the clock. They also assume that the line starts each subframe from the low level that the even parity keeps, so the boundary and cell-toggle properties hold only when the strobe is never issued during reset.

The stimulus keeps inputs stable across the beginning strobe of each subframe and changes them at random during the rest of it. Strobes are spaced by random idle gaps of zero or one cycle, so both back-to-back and sparse strobe patterns are covered. Channel flags alternate apart from one directed back-to-back channel-A case, and enough subframes run to pass the 192-frame block wrap.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
   localparam int SLOT_CNT    = 32;
   localparam int HALF_CNT    = 2 * SLOT_CNT;
   localparam int HALF_W      = $clog2(HALF_CNT);
   localparam int PRE_SLOTS   = 4;
   localparam int PRE_HALVES  = 2 * PRE_SLOTS;
   localparam int AUX_LO      = 4;
   localparam int SMP_LO      = 12;
   localparam int VAL_SLOT    = 28;
   localparam int USR_SLOT    = 29;
   localparam int CST_SLOT    = 30;
   localparam int PAR_SLOT    = 31;

   localparam logic [PRE_HALVES-1:0] PRE_BLOCK = 8'b1110_1000;
   localparam logic [PRE_HALVES-1:0] PRE_CHA   = 8'b1110_0010;
   localparam logic [PRE_HALVES-1:0] PRE_CHB   = 8'b1110_0100;

   typedef enum logic {
      SRC_PCM = 1'b0,
      SRC_FMT = 1'b1
   } src_sel_e;
endpackage

// File: rtl/spdif_src_mux.sv
module spdif_src_mux
   import spdif_tx_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] pcm_word,
   input  logic                pcm_vld,
   input  logic [SAMPLE_W-1:0] fmt_word,
   input  logic                fmt_vld,
   input  logic                src_sel,
   output logic [SAMPLE_W-1:0] sel_word,
   output logic                sel_vld
);
   src_sel_e src;

   always_comb begin
      src      = src_sel_e'(src_sel);
      sel_vld  = (src == SRC_FMT) ? fmt_vld  : pcm_vld;
      sel_word = (src == SRC_FMT) ? fmt_word : pcm_word;
      // an absent sample is sent as silence
      if (!sel_vld) sel_word = '0;
   end
endmodule

// File: rtl/spdif_sf_builder.sv
module spdif_sf_builder
   import spdif_tx_pkg::*;
#(
   parameter int                        SAMPLE_W         = 16,
   parameter int                        FRAMES_PER_BLOCK = 192,
   parameter logic [FRAMES_PER_BLOCK-1:0] CS_WORD        = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [SAMPLE_W-1:0]   word,
   input  logic                  vld,
   input  logic                  chan_b,
   output logic [PRE_HALVES-1:0] pre_now,
   output logic [PRE_HALVES-1:0] pre_q,
   output logic [SLOT_CNT-1:0]   bits_q
);
   localparam int BLK_W = $clog2(FRAMES_PER_BLOCK);
   localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(FRAMES_PER_BLOCK - 1);

   logic [BLK_W-1:0]    blk_cnt;
   logic [BLK_W-1:0]    last_idx;
   logic [BLK_W-1:0]    cs_idx;
   logic [SLOT_CNT-1:0] bits_nxt;

   always_comb begin
      if (chan_b)              pre_now = PRE_CHB;
      else if (blk_cnt == '0)  pre_now = PRE_BLOCK;
      else                     pre_now = PRE_CHA;
      cs_idx = chan_b ? last_idx : blk_cnt;
   end

   always_comb begin
      bits_nxt                     = '0;
      bits_nxt[SMP_LO +: SAMPLE_W] = word;
      bits_nxt[VAL_SLOT]           = ~vld;
      bits_nxt[USR_SLOT]           = 1'b0;
      bits_nxt[CST_SLOT]           = CS_WORD[cs_idx];
      bits_nxt[PAR_SLOT]           = ^bits_nxt[PAR_SLOT-1:AUX_LO];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q    <= '0;
         bits_q   <= '0;
         blk_cnt  <= '0;
         last_idx <= '0;
      end else if (load) begin
         pre_q  <= pre_now;
         bits_q <= bits_nxt;
         if (!chan_b) begin
            last_idx <= blk_cnt;
            blk_cnt  <= (blk_cnt == BLK_LAST) ? '0 : blk_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
   import spdif_tx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  half_en,
   input  logic [PRE_HALVES-1:0] pre_now,
   input  logic [PRE_HALVES-1:0] pre_q,
   input  logic [SLOT_CNT-1:0]   bits_q,
   output logic                  load,
   output logic [HALF_W-1:0]     idx,
   output logic                  line
);
   logic inv;

   assign load = half_en && (idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         line <= 1'b0;
         inv  <= 1'b0;
      end else if (half_en) begin
         idx <= idx + 1'b1;
         if (idx == '0) begin
            line <= pre_now[PRE_HALVES-1] ^ line;
            inv  <= line;
         end else if (idx < HALF_W'(PRE_HALVES)) begin
            line <= pre_q[~idx[2:0]] ^ inv;
         end else if (!idx[0]) begin
            line <= ~line;
         end else begin
            line <= line ^ bits_q[idx[HALF_W-1:1]];
         end
      end
   end
endmodule

// File: rtl/spdif_biphase_tx.sv
module spdif_biphase_tx
   import spdif_tx_pkg::*;
#(
   parameter int                          SAMPLE_W         = 16,
   parameter int                          FRAMES_PER_BLOCK = 192,
   parameter logic [FRAMES_PER_BLOCK-1:0] CS_WORD          = 'h6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_en,
   input  logic [SAMPLE_W-1:0] pcm_word,
   input  logic                pcm_vld,
   input  logic [SAMPLE_W-1:0] fmt_word,
   input  logic                fmt_vld,
   input  logic                src_sel,
   input  logic                chan_b,
   output logic                line_out
);
   generate
      if (SAMPLE_W != 16) begin : g_bad_width
         $error("spdif_biphase_tx: only 16-bit samples are supported");
      end
      if (SMP_LO + SAMPLE_W > VAL_SLOT) begin : g_bad_fit
         $error("spdif_biphase_tx: sample does not fit its slots");
      end
      if (FRAMES_PER_BLOCK < 2) begin : g_bad_block
         $error("spdif_biphase_tx: block length too short");
      end
   endgenerate

   logic [SAMPLE_W-1:0]   sel_word;
   logic                  sel_vld;
   logic [PRE_HALVES-1:0] pre_now;
   logic [PRE_HALVES-1:0] pre_q;
   logic [SLOT_CNT-1:0]   sf_bits;
   logic                  load_stb;
   logic [HALF_W-1:0]     enc_idx;

   spdif_src_mux #(.SAMPLE_W(SAMPLE_W)) i_mux (
      .pcm_word (pcm_word),
      .pcm_vld  (pcm_vld),
      .fmt_word (fmt_word),
      .fmt_vld  (fmt_vld),
      .src_sel  (src_sel),
      .sel_word (sel_word),
      .sel_vld  (sel_vld)
   );

   spdif_sf_builder #(
      .SAMPLE_W         (SAMPLE_W),
      .FRAMES_PER_BLOCK (FRAMES_PER_BLOCK),
      .CS_WORD          (CS_WORD)
   ) i_build (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_stb),
      .word    (sel_word),
      .vld     (sel_vld),
      .chan_b  (chan_b),
      .pre_now (pre_now),
      .pre_q   (pre_q),
      .bits_q  (sf_bits)
   );

   spdif_bmc_enc i_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .half_en (half_en),
      .pre_now (pre_now),
      .pre_q   (pre_q),
      .bits_q  (sf_bits),
      .load    (load_stb),
      .idx     (enc_idx),
      .line    (line_out)
   );
endmodule

// File: rtl/spdif_tx_checker.sv
module spdif_tx_checker
   import spdif_tx_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                half_en,
   input logic                line,
   input logic [HALF_W-1:0]   idx,
   input logic                load,
   input logic                sel_vld,
   input logic [SLOT_CNT-1:0] sf_bits
);
   a_r10_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !half_en |=> $stable(line));

   a_r11_wrap_after_64: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && idx == HALF_W'(HALF_CNT - 1)) |=> (idx == '0));

   a_r11_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !half_en |=> $stable(idx));

   a_r6_cell_start_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && idx >= HALF_W'(PRE_HALVES) && !idx[0]) |=> (line != $past(line)));

   a_r7_boundary_low: assert property (@(posedge clk) disable iff (!rst_n)
      (half_en && idx == '0) |-> !line);

   a_r4_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !sel_vld) |=> (sf_bits[VAL_SLOT] && sf_bits[SMP_LO +: 16] == '0));

   a_r5_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ($countones(sf_bits[PAR_SLOT:AUX_LO]) % 2 == 0));
endmodule

bind spdif_biphase_tx spdif_tx_checker i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .half_en (half_en),
   .line    (line_out),
   .idx     (enc_idx),
   .load    (load_stb),
   .sel_vld (sel_vld),
   .sf_bits (sf_bits)
);

// File: tb/test_spdif_biphase_tx.sv
module test_spdif_biphase_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        half_en = 1'b0;
   logic [15:0] pcm_word = '0;
   logic        pcm_vld = 1'b0;
   logic [15:0] fmt_word = '0;
   logic        fmt_vld = 1'b0;
   logic        src_sel = 1'b0;
   logic        chan_b = 1'b0;
   logic        line_out;

   localparam logic [191:0] CS = 192'h6;

   int vec = 0;
   int mis = 0;
   int blk = 0;
   int last_a = 0;

   always #4 clk = ~clk;

   spdif_biphase_tx i_spdif_biphase_tx (
      .clk(clk), .rst_n(rst_n), .half_en(half_en),
      .pcm_word(pcm_word), .pcm_vld(pcm_vld),
      .fmt_word(fmt_word), .fmt_vld(fmt_vld),
      .src_sel(src_sel), .chan_b(chan_b), .line_out(line_out));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      vec++;
      if (!ok) begin
         mis++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic strobe(output logic st);
      half_en = 1'b1;
      @(negedge clk);
      st = line_out;
      half_en = 1'b0;
      repeat ($urandom % 2) begin
         @(negedge clk);
         chk(line_out == st, "R10 line held between strobes", 64'(line_out), 64'(st));
      end
   endtask

   task automatic send_sf(input logic [15:0] pw, input logic pv,
                          input logic [15:0] fw, input logic fv,
                          input logic sel, input logic ch);
      logic [63:0] obs;
      logic [63:0] exp;
      logic [31:0] b;
      logic [7:0]  pat;
      logic [15:0] w;
      logic        v, lvl, z, st;
      int          k;
      pcm_word = pw; pcm_vld = pv; fmt_word = fw; fmt_vld = fv;
      src_sel = sel; chan_b = ch;
      for (int i = 0; i < 64; i++) begin
         strobe(st);
         obs[i] = st;
         if (i == 0) begin
            // R11: later input changes must not reach this subframe
            pcm_word = 16'($urandom); fmt_word = 16'($urandom);
            pcm_vld = 1'($urandom); fmt_vld = 1'($urandom);
            src_sel = 1'($urandom); chan_b = 1'($urandom);
         end
      end
      // model
      v = sel ? fv : pv;
      w = v ? (sel ? fw : pw) : 16'h0;
      z = 1'b0;
      if (ch) begin
         k = last_a; pat = 8'b1110_0100;
      end else begin
         k = blk; z = (blk == 0);
         pat = z ? 8'b1110_1000 : 8'b1110_0010;
         last_a = blk; blk = (blk + 1) % 192;
      end
      b = '0;
      b[27:12] = w;
      b[28] = ~v;
      b[30] = CS[k];
      b[31] = ^b[30:4];
      for (int i = 0; i < 8; i++) exp[i] = pat[7-i];
      lvl = exp[7];
      for (int s = 4; s < 32; s++) begin
         lvl = ~lvl; exp[2*s] = lvl;
         if (b[s]) lvl = ~lvl;
         exp[2*s+1] = lvl;
      end
      // decode observed slots
      for (int s = 4; s < 32; s++) begin
         chk(obs[2*s] != obs[2*s-1], "R6 cell start toggle",
             64'(obs[2*s]), 64'(!obs[2*s-1]));
      end
      chk(obs[7:0] == exp[7:0], z ? "R8 block-start preamble" : "R7 preamble",
          64'(obs[7:0]), 64'(exp[7:0]));
      chk(obs[63] == 1'b0, "R7 boundary level low", 64'(obs[63]), 64'h0);
      for (int s = 4; s < 12; s++)
         chk(obs[2*s] == obs[2*s+1], "R3 aux slot zero", 64'(s), 64'(s));
      begin
         logic [15:0] dw;
         for (int s = 12; s < 28; s++) dw[s-12] = obs[2*s] ^ obs[2*s+1];
         chk(dw == w, sel ? "R3 R2 formatter sample" : "R3 R2 PCM sample",
             64'(dw), 64'(w));
      end
      chk((obs[56] ^ obs[57]) == ~v, "R4 validity slot", 64'(obs[56] ^ obs[57]), 64'(~v));
      chk((obs[58] ^ obs[59]) == 1'b0, "R4 user slot", 64'(obs[58] ^ obs[59]), 64'h0);
      chk((obs[60] ^ obs[61]) == CS[k], "R9 channel status", 64'(obs[60] ^ obs[61]),
          64'(CS[k]));
      chk((obs[62] ^ obs[63]) == b[31], "R5 parity slot", 64'(obs[62] ^ obs[63]),
          64'(b[31]));
      chk(obs == exp, "R6 R11 full subframe", obs, exp);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      vec++; mis++;
      $display("FAIL R11 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk(line_out == 1'b0, "R1 line low in reset", 64'(line_out), 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(line_out == 1'b0, "R1 line low after reset", 64'(line_out), 64'h0);
      // directed corners
      send_sf(16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
      send_sf(16'h0000, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b1);
      send_sf(16'h1234, 1'b1, 16'h8001, 1'b1, 1'b1, 1'b0);
      send_sf(16'h5A5A, 1'b0, 16'h8001, 1'b1, 1'b0, 1'b1);
      send_sf(16'h5A5A, 1'b1, 16'hC3C3, 1'b0, 1'b1, 1'b0);
      send_sf(16'h0001, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0);
      send_sf(16'h8000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b1);
      // constrained random, alternating channels, past one block wrap
      for (int n = 0; n < 392; n++) begin
         send_sf(16'($urandom), ($urandom % 8) != 0, 16'($urandom),
                 ($urandom % 8) != 0, 1'($urandom), 1'(n % 2));
      end
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
   end
endmodule